// File: doc/BRIEF.md
# Two-Read One-Write General Register Bank

This block is a bank of general-purpose registers for a small datapath. It has two read ports and one write port. By default it holds 32 entries of 16 bits, selected by 5-bit indices. Each read port is purely combinational: its data output follows its index with no clock involved. Index zero is a constant-zero register. Whatever the cell behind index zero holds, a read of index zero returns zero on either port.

The write port is sampled only on the rising clock edge. It updates the selected entry when its enable is high. A synchronous, active-high reset clears every entry and overrides a write presented in the same cycle. No storage element is level-sensitive.

A read of the entry being written returns the old contents for the whole cycle. The new value appears only after the edge. There is no bypass from the write port to the read ports.

Top module: `gprf_2r1w`

## Requirements
- R1: A rising edge with `rst` high leaves every entry holding zero, so every index reads 0 on both ports afterwards.
- R2: Reset takes priority: a write presented in a reset cycle is discarded, and its target still reads 0 after the edge.
- R3: On a rising edge with `wr_go` = 1 and `rst` = 0, the entry at `wr_idx` takes `wr_value` and is visible on reads after that edge.
- R4: With `wr_go` = 0, an edge changes no entry, whatever `wr_idx` and `wr_value` hold.
- R5: Each read data output follows its index combinationally, with no clock edge needed between an index change and the new data.
- R6: Index 0 reads as 16'h0000 on both ports at all times, including after a write to index 0.
- R7: A read of the index being written in the same cycle returns the previous contents until the rising edge.
- R8: The two read ports are independent: each returns the entry at its own index in the same cycle, including when both select the same index.
- R9: A write changes only its target entry; all other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage updates on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| rport0_idx | input | 5 | Index for read port 0 |
| rport0_data | output | 16 | Combinational read data for port 0 |
| rport1_idx | input | 5 | Index for read port 1 |
| rport1_data | output | 16 | Combinational read data for port 1 |
| wr_go | input | 1 | Write enable |
| wr_idx | input | 5 | Index of the entry to write |
| wr_value | input | 16 | Data to write |

## Verification
A fixed vector table drives a set of interleaved cases:
- writes to the top, bottom and middle indices, and to index zero;
- idle cycles that carry a live index and data with the enable low;
- reads of the entry being written in the same cycle.

Together these cases separate a correct bank from one that:
- bypasses the write to the read ports;
- ignores the enable;
- leaks the cell behind index zero;
- cross-wires the two ports.

A long pseudo-random sequence of mixed writes and reads is compared against a reference array, and a final sweep of every index catches writes that strayed into neighbouring entries. Directed cases cover the state after reset, reset overriding a write, and index changes between clock edges, which show that reads need no clock.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

    localparam int unsigned GPRF_ENTRIES = 32;
    localparam int unsigned GPRF_DATA_W  = 16;

    // True when an index selects the constant-zero register.
    function automatic logic is_zero_reg(input logic [31:0] idx);
        return (idx == 32'd0);
    endfunction

    // True when an index falls inside the populated range of the bank.
    function automatic logic idx_in_range(input logic [31:0] idx, input int unsigned entries);
        return (idx < entries);
    endfunction

endpackage

// File: rtl/gprf_cells.sv
module gprf_cells #(
    parameter int unsigned ENTRIES = gprf_pkg::GPRF_ENTRIES,
    parameter int unsigned DATA_W  = gprf_pkg::GPRF_DATA_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_go,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [DATA_W-1:0]               wr_value,
    output logic [ENTRIES-1:0][DATA_W-1:0]  cells_o
);

    // One-hot write select, one bit per entry.
    logic [ENTRIES-1:0] sel;

    always_comb begin
        sel = '0;
        if (wr_go && gprf_pkg::idx_in_range(32'(wr_idx), ENTRIES))
            sel[wr_idx] = 1'b1;
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (sel[e])
                q <= wr_value;
        end
        assign cells_o[e] = q;
    end

    // R1: the cycle after a reset edge, every entry is zero.
    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cells_o == '0));

    // R3: an enabled write lands in its target entry.
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_go && !rst) |=> (cells_o[$past(wr_idx)] == $past(wr_value)));

    // R4: without the enable, no entry moves.
    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_go && !rst) |=> $stable(cells_o));

    // R9: an enabled write selects exactly one entry.
    assert_single_target_R9: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> $onehot0(sel));

endmodule

// File: rtl/gprf_rdport.sv
module gprf_rdport #(
    parameter int unsigned ENTRIES = gprf_pkg::GPRF_ENTRIES,
    parameter int unsigned DATA_W  = gprf_pkg::GPRF_DATA_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][DATA_W-1:0]  cells_i,
    input  logic [IDX_W-1:0]                idx,
    output logic [DATA_W-1:0]               data
);

    always_comb begin
        data = '0;
        if (!gprf_pkg::is_zero_reg(32'(idx)) &&
            gprf_pkg::idx_in_range(32'(idx), ENTRIES))
            data = cells_i[idx];
    end

endmodule

// File: rtl/gprf_2r1w.sv
module gprf_2r1w #(
    parameter int unsigned ENTRIES = gprf_pkg::GPRF_ENTRIES,
    parameter int unsigned DATA_W  = gprf_pkg::GPRF_DATA_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned NPORTS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rport0_idx,
    output logic [DATA_W-1:0] rport0_data,
    input  logic [IDX_W-1:0]  rport1_idx,
    output logic [DATA_W-1:0] rport1_data,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_value
);

    logic [ENTRIES-1:0][DATA_W-1:0] cells;
    logic [NPORTS-1:0][IDX_W-1:0]   rd_idx;
    logic [NPORTS-1:0][DATA_W-1:0]  rd_data;

    gprf_cells #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_cells (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (wr_go),
        .wr_idx   (wr_idx),
        .wr_value (wr_value),
        .cells_o  (cells)
    );

    assign rd_idx[0] = rport0_idx;
    assign rd_idx[1] = rport1_idx;

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        gprf_rdport #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_port (
            .cells_i (cells),
            .idx     (rd_idx[p]),
            .data    (rd_data[p])
        );
    end

    assign rport0_data = rd_data[0];
    assign rport1_data = rd_data[1];

    // R6: index zero reads zero on both ports.
    assert_zero_reg_p0_R6: assert property (@(posedge clk) disable iff (rst)
        (rport0_idx == '0) |-> (rport0_data == '0));
    assert_zero_reg_p1_R6: assert property (@(posedge clk) disable iff (rst)
        (rport1_idx == '0) |-> (rport1_data == '0));

    // R7: data written to a held nonzero index shows only after the edge.
    assert_visible_after_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_go && (wr_idx != '0) && (rport0_idx == wr_idx)) |=>
            (!$stable(rport0_idx) || (rport0_data == $past(wr_value))));

endmodule

// File: tb/test_gprf_2r1w.sv
module test_gprf_2r1w;

    localparam int ENTRIES = 32;
    localparam int DW      = 16;
    localparam int NVEC    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    rport0_idx = '0, rport1_idx = '0, wr_idx = '0;
    logic [DW-1:0] rport0_data, rport1_data, wr_value = '0;
    logic          wr_go = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [ENTRIES];

    always #10 clk = ~clk;  // 50 MHz

    gprf_2r1w i_gprf_2r1w (
        .clk(clk), .rst(rst),
        .rport0_idx(rport0_idx), .rport0_data(rport0_data),
        .rport1_idx(rport1_idx), .rport1_data(rport1_data),
        .wr_go(wr_go), .wr_idx(wr_idx), .wr_value(wr_value)
    );

    // Vector: {go, wr_idx, wr_value, port0 idx, port1 idx}
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b1, 5'd3,  16'hA5A5, 5'd3,  5'd0 },  // R7 old value while writing
        {1'b1, 5'd0,  16'hFFFF, 5'd0,  5'd3 },  // R6 write to zero
        {1'b0, 5'd4,  16'h1234, 5'd4,  5'd0 },  // R4 idle with live data
        {1'b1, 5'd31, 16'h8001, 5'd4,  5'd31},  // R3 top index
        {1'b1, 5'd4,  16'h0F0F, 5'd31, 5'd3 },  // R8 independent ports
        {1'b1, 5'd3,  16'h5A5A, 5'd3,  5'd4 },  // R7 overwrite
        {1'b0, 5'd3,  16'hDEAD, 5'd3,  5'd0 },  // R4
        {1'b1, 5'd1,  16'h0001, 5'd0,  5'd0 },  // R6 both ports zero
        {1'b1, 5'd2,  16'h0002, 5'd1,  5'd1 },  // R8 same index both ports
        {1'b1, 5'd0,  16'h7777, 5'd2,  5'd0 },  // R6
        {1'b0, 5'd0,  16'h0000, 5'd0,  5'd2 },  // R6
        {1'b1, 5'd16, 16'hC3C3, 5'd16, 5'd31},  // R3 middle index
        {1'b1, 5'd15, 16'h3C3C, 5'd16, 5'd15},  // R9 neighbour
        {1'b1, 5'd17, 16'hFFFF, 5'd15, 5'd16},  // R9 neighbour
        {1'b0, 5'd17, 16'h0000, 5'd17, 5'd16},  // R4
        {1'b1, 5'd31, 16'h0000, 5'd31, 5'd17}   // R3 write zero
    };

    function automatic logic [DW-1:0] expect_rd(input logic [4:0] i);
        return (i == 5'd0) ? '0 : model[i];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic go, input logic [4:0] wa, input logic [DW-1:0] wd,
                        input logic [4:0] a0, input logic [4:0] a1, input string req);
        @(negedge clk);
        wr_go = go; wr_idx = wa; wr_value = wd;
        rport0_idx = a0; rport1_idx = a1;
        #5;
        check(req, rport0_data, expect_rd(a0));
        check(req, rport1_data, expect_rd(a1));
        @(posedge clk);
        #1;
        if (rst) begin
            for (int k = 0; k < ENTRIES; k++) model[k] = '0;
        end else if (go) begin
            model[wa] = wd;
        end
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < ENTRIES; k++) begin
            @(negedge clk);
            wr_go = 1'b0;
            rport0_idx = 5'(k); rport1_idx = 5'(ENTRIES - 1 - k);
            #5;
            check(req, rport0_data, expect_rd(5'(k)));
            check(req, rport1_data, expect_rd(5'(ENTRIES - 1 - k)));
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [31:0] v;
        for (int k = 0; k < ENTRIES; k++) model[k] = '0;

        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        sweep("R1 reset state");

        // Table walk
        for (int n = 0; n < NVEC; n++) begin
            v = VEC[n];
            step(v[31], v[30:26], v[25:10], v[9:5], v[4:0], "R3/R4/R6/R7/R8 table");
        end
        sweep("R9 after table");

        // R5: reads follow index with no clock edge
        @(negedge clk);
        wr_go = 1'b0;
        rport0_idx = 5'd16; rport1_idx = 5'd15;
        #2;
        check("R5 async p0", rport0_data, expect_rd(5'd16));
        check("R5 async p1", rport1_data, expect_rd(5'd15));
        rport0_idx = 5'd15; rport1_idx = 5'd16;
        #2;
        check("R5 async p0 swap", rport0_data, expect_rd(5'd15));
        check("R5 async p1 swap", rport1_data, expect_rd(5'd16));

        // Random sequence against reference array
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic [DW-1:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d = lfsr ^ 16'(n * 40503);
            step(lfsr[0] | lfsr[7], lfsr[5:1], d, lfsr[10:6], lfsr[15:11],
                 "R3/R6/R7/R8 random");
        end
        sweep("R9 after random");

        // R2: reset overrides a write in the same cycle
        step(1'b1, 5'd9, 16'h9999, 5'd9, 5'd0, "R3 pre-reset write");
        @(negedge clk);
        rst = 1'b1; wr_go = 1'b1; wr_idx = 5'd9; wr_value = 16'h4242;
        @(posedge clk); #1;
        for (int k = 0; k < ENTRIES; k++) model[k] = '0;
        @(negedge clk);
        rst = 1'b0; wr_go = 1'b0; rport0_idx = 5'd9;
        #5;
        check("R2 reset beats write", rport0_data, 16'h0000);
        sweep("R1 after second reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule